// File: doc/BRIEF.md
# Mixed-Width Dual-Port Block Memory

This block is a 36-kilobit synchronous memory with two independent access ports, A and B. Each port has its own enable, write enable, address, write data and read data, and each picks its word width by parameter from 1, 2, 4, 9, 18 or 36 bits. Both ports address the same physical storage: 1024 rows, each row holding 32 data bits and 4 parity bits. A word written through a wide port can therefore be read back in slices through a narrow port, and the reverse.

The 9, 18 and 36 bit widths carry one parity bit for every data byte in the top bits of the port word. The 1, 2 and 4 bit widths reach only data bits and never touch parity. Both ports run on one shared clock. This keeps the rule for a same-cycle collision exact: port A wins where both ports write the same bits, and a read on one port of bits the other port writes in that cycle returns the old contents.

Top module: `mixed_width_tdpram`

## Requirements
- R1: A port word of width W in {9,18,36} is {parity[W/9-1:0], data[8*(W/9)-1:0]}; for W in {1,2,4} the port word is data only, and a write changes exactly W stored bits.
- R2: With D data bits per port word and L = 32/D lanes per row, port address a selects row a / L and lane a mod L. Lane i covers row data bits [i*D +: D] and row parity bits [i*P +: P], where P is the port's parity width, so lower lanes sit at lower bit positions.
- R3: Reads are synchronous: the read data for an enabled access appears after the first rising clock edge following the cycle in which the address is presented.
- R4: A write on a port returns, in the same access, the contents the addressed word held before the write (read-first).
- R5: When both ports write overlapping bits in the same cycle, the port A value is stored in those bits. Bits that only port B writes take the port B value.
- R6: A read on one port of bits the other port writes in that same cycle returns the old contents. The next read returns the new contents.
- R7: While a port's enable is low, its read data holds its value and its write enable has no effect on storage.
- R8: A write through a narrow port (1, 2 or 4 bits) leaves every parity bit and every other lane of the row unchanged.
- R9: A synchronous active-high reset clears both read data outputs to zero. Accesses presented during reset neither write storage nor load read data. Storage contents survive reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for both ports |
| rst | input | 1 | Synchronous active-high reset of the read data registers |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write enable, qualified by a_en |
| a_addr | input | A_AW | Port A word address (10 + log2(32/data bits)) |
| a_din | input | A_WIDTH | Port A write word |
| a_dout | output | A_WIDTH | Port A registered read word |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write enable, qualified by b_en |
| b_addr | input | B_AW | Port B word address |
| b_din | input | B_WIDTH | Port B write word |
| b_dout | output | B_WIDTH | Port B registered read word |

## Verification
A wrong lane shift or row split puts data in the wrong slice of a row. This shows only when the other port, at its different width, reads that row back, so cross-width reads follow every directed write within one or two cycles. A broken merge of same-cycle writes either loses the port A bits or corrupts the neighbouring port B bits. That appears on the next read of that row, which the directed collision case issues on the following cycle. A read register that reloads while idle, or that shows new data instead of old data, differs from the expected word on the very edge the access completes.

// File: rtl/tdpram_pkg.sv
package tdpram_pkg;

    localparam int ROWS      = 1024;
    localparam int ROW_AW    = 10;
    localparam int ROW_DBITS = 32;
    localparam int ROW_PBITS = 4;

    // One physical row: parity above data.
    typedef struct packed {
        logic [ROW_PBITS-1:0] par;
        logic [ROW_DBITS-1:0] data;
    } row_t;

    // Row-level write request produced by a port front end.
    typedef struct packed {
        logic              we;
        logic [ROW_AW-1:0] row;
        row_t              mask;
        row_t              wdata;
    } row_req_t;

    function automatic int data_bits(int w);
        return (w >= 9) ? (w / 9) * 8 : w;
    endfunction

    function automatic int par_bits(int w);
        return (w >= 9) ? w / 9 : 0;
    endfunction

    function automatic int lane_bits(int w);
        return $clog2(ROW_DBITS / data_bits(w));
    endfunction

    function automatic int addr_bits(int w);
        return ROW_AW + lane_bits(w);
    endfunction

    function automatic row_t merge_row(row_t old, row_t mask, row_t wd);
        return row_t'((old & ~mask) | (wd & mask));
    endfunction

endpackage

// File: rtl/tdpram_port.sv
module tdpram_port
    import tdpram_pkg::*;
#(
    parameter  int WIDTH = 36,
    localparam int DW    = data_bits(WIDTH),
    localparam int PW    = par_bits(WIDTH),
    localparam int LB    = lane_bits(WIDTH),
    localparam int AW    = ROW_AW + LB
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] din,
    output row_req_t         req,
    input  row_t             rd_row,
    output logic [WIDTH-1:0] dout
);

    localparam int LBW = (LB > 0) ? LB : 1;
    localparam logic [ROW_DBITS-1:0] DMASK0 = 32'((64'd1 << DW) - 64'd1);
    localparam logic [ROW_PBITS-1:0] PMASK0 = 4'((8'd1 << PW) - 8'd1);

    logic             act;
    logic [LBW-1:0]   lane;
    int               dsh;
    int               psh;
    logic [31:0]      dfield;
    logic [3:0]       pfield;
    logic [DW-1:0]    dsel;
    logic [WIDTH-1:0] rd_word;

    assign act = en & ~rst;

    generate
        if (LB == 0) begin : g_one_lane
            assign lane = '0;
        end else begin : g_lanes
            assign lane = addr[LB-1:0];
        end
    endgenerate

    assign dsh  = int'(lane) * DW;
    assign psh  = int'(lane) * PW;
    assign dsel = rd_row.data[dsh +: DW];

    generate
        if (PW == 0) begin : g_no_par
            logic unused_par;
            assign unused_par = ^rd_row.par;
            assign dfield     = 32'(din);
            assign pfield     = '0;
            assign rd_word    = dsel;
        end else begin : g_par
            logic [PW-1:0] psel;
            assign psel    = rd_row.par[psh +: PW];
            assign dfield  = 32'(din[DW-1:0]);
            assign pfield  = 4'(din[WIDTH-1:DW]);
            assign rd_word = {psel, dsel};
        end
    endgenerate

    always_comb begin
        req.we         = act & we;
        req.row        = addr[AW-1 -: ROW_AW];
        req.mask.data  = DMASK0 << dsh;
        req.mask.par   = PMASK0 << psh;
        req.wdata.data = dfield << dsh;
        req.wdata.par  = pfield << psh;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (en) begin
            dout <= rd_word;
        end
    end

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(dout));

    // R9
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (dout == '0));

    // R1
    write_span_chk: assert property (@(posedge clk) disable iff (rst)
        (en && we) |-> ($countones({req.mask.par, req.mask.data}) == WIDTH));

endmodule

// File: rtl/tdpram_array.sv
module tdpram_array
    import tdpram_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  row_req_t req_a,
    input  row_req_t req_b,
    output row_t     rd_a,
    output row_t     rd_b
);

    row_t mem [ROWS];

    row_t b_new;
    row_t a_base;
    row_t a_new;
    logic same_row;

    assign same_row = (req_a.row == req_b.row);
    assign b_new    = merge_row(mem[req_b.row], req_b.mask, req_b.wdata);
    assign a_base   = (req_b.we && same_row) ? b_new : mem[req_a.row];
    assign a_new    = merge_row(a_base, req_a.mask, req_a.wdata);

    // Port B lands first; port A then overrides any shared bits.
    always_ff @(posedge clk) begin
        if (req_b.we) mem[req_b.row] <= b_new;
        if (req_a.we) mem[req_a.row] <= a_new;
    end

    // Old contents: array reads see state before this edge's writes.
    assign rd_a = mem[req_a.row];
    assign rd_b = mem[req_b.row];

    // Shadow of the last write requests, for the checks below.
    logic              a_we_q, b_solo_q;
    logic [ROW_AW-1:0] a_row_q, b_row_q;
    logic [35:0]       a_mask_q, a_wd_q, b_mask_q, b_wd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_we_q   <= 1'b0;
            b_solo_q <= 1'b0;
        end else begin
            a_we_q   <= req_a.we;
            b_solo_q <= req_b.we &&
                        !(req_a.we && same_row && |(req_a.mask & req_b.mask));
        end
        a_row_q  <= req_a.row;
        a_mask_q <= req_a.mask;
        a_wd_q   <= req_a.wdata;
        b_row_q  <= req_b.row;
        b_mask_q <= req_b.mask;
        b_wd_q   <= req_b.wdata;
    end

    // R5
    a_lands_chk: assert property (@(posedge clk) disable iff (rst)
        a_we_q |-> (((mem[a_row_q] ^ a_wd_q) & a_mask_q) == '0));

    // R5
    b_lands_chk: assert property (@(posedge clk) disable iff (rst)
        b_solo_q |-> (((mem[b_row_q] ^ b_wd_q) & b_mask_q) == '0));

endmodule

// File: rtl/mixed_width_tdpram.sv
module mixed_width_tdpram
    import tdpram_pkg::*;
#(
    parameter  int A_WIDTH = 36,
    parameter  int B_WIDTH = 9,
    localparam int A_AW    = addr_bits(A_WIDTH),
    localparam int B_AW    = addr_bits(B_WIDTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               a_en,
    input  logic               a_we,
    input  logic [A_AW-1:0]    a_addr,
    input  logic [A_WIDTH-1:0] a_din,
    output logic [A_WIDTH-1:0] a_dout,
    input  logic               b_en,
    input  logic               b_we,
    input  logic [B_AW-1:0]    b_addr,
    input  logic [B_WIDTH-1:0] b_din,
    output logic [B_WIDTH-1:0] b_dout
);

    row_req_t req_a, req_b;
    row_t     rd_a, rd_b;

    tdpram_port #(.WIDTH(A_WIDTH)) u_port_a (
        .clk    (clk),
        .rst    (rst),
        .en     (a_en),
        .we     (a_we),
        .addr   (a_addr),
        .din    (a_din),
        .req    (req_a),
        .rd_row (rd_a),
        .dout   (a_dout)
    );

    tdpram_port #(.WIDTH(B_WIDTH)) u_port_b (
        .clk    (clk),
        .rst    (rst),
        .en     (b_en),
        .we     (b_we),
        .addr   (b_addr),
        .din    (b_din),
        .req    (req_b),
        .rd_row (rd_b),
        .dout   (b_dout)
    );

    tdpram_array u_array (
        .clk   (clk),
        .rst   (rst),
        .req_a (req_a),
        .req_b (req_b),
        .rd_a  (rd_a),
        .rd_b  (rd_b)
    );

endmodule

// File: tb/mixed_width_tdpram_tb.sv
module mixed_width_tdpram_tb;

    localparam int WA = 18;
    localparam int WB = 4;
    localparam int AWA = 11;
    localparam int AWB = 13;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic           a_en = 0, a_we = 0, b_en = 0, b_we = 0;
    logic [AWA-1:0] a_addr = '0;
    logic [AWB-1:0] b_addr = '0;
    logic [WA-1:0]  a_din = '0, a_dout;
    logic [WB-1:0]  b_din = '0, b_dout;

    mixed_width_tdpram #(.A_WIDTH(WA), .B_WIDTH(WB)) u_dut (
        .clk(clk), .rst(rst),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_din(a_din), .a_dout(a_dout),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_din(b_din), .b_dout(b_dout)
    );

    // Reference storage: 32 data + 4 parity bits per row.
    logic [31:0] md [1024];
    logic [3:0]  mp [1024];
    logic [WA-1:0] exp_a = '0;
    logic [WB-1:0] exp_b = '0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    function automatic logic [WA-1:0] ref_rd_a(logic [AWA-1:0] ad);
        int r = int'(ad[AWA-1:1]);
        int l = int'(ad[0]);
        return {mp[r][l*2 +: 2], md[r][l*16 +: 16]};
    endfunction

    function automatic logic [WB-1:0] ref_rd_b(logic [AWB-1:0] ad);
        int r = int'(ad[AWB-1:3]);
        int l = int'(ad[2:0]);
        return md[r][l*4 +: 4];
    endfunction

    task automatic check(string tag, logic [35:0] act, logic [35:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(string tag,
                        logic ea, logic wa, logic [AWA-1:0] aa, logic [WA-1:0] da,
                        logic eb, logic wb, logic [AWB-1:0] ab, logic [WB-1:0] db);
        a_en = ea; a_we = wa; a_addr = aa; a_din = da;
        b_en = eb; b_we = wb; b_addr = ab; b_din = db;
        if (rst) begin
            exp_a = '0;
            exp_b = '0;
        end else begin
            if (ea) exp_a = ref_rd_a(aa);
            if (eb) exp_b = ref_rd_b(ab);
            if (eb && wb) md[int'(ab[AWB-1:3])][int'(ab[2:0])*4 +: 4] = db;
            if (ea && wa) begin
                md[int'(aa[AWA-1:1])][int'(aa[0])*16 +: 16] = da[15:0];
                mp[int'(aa[AWA-1:1])][int'(aa[0])*2 +: 2]   = da[17:16];
            end
        end
        @(posedge clk);
        @(negedge clk);
        check({tag, " port A"}, 36'(a_dout), 36'(exp_a));
        check({tag, " port B"}, 36'(b_dout), 36'(exp_b));
    endtask

    task automatic idle();
        step("R7", 0, 0, '0, '0, 0, 0, '0, '0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R9: outputs cleared while reset is held
        @(negedge clk);
        step("R9", 1, 1, '0, 18'h3FFFF, 1, 1, '0, 4'hF);
        rst = 1'b0;

        // Fill the rows used below through port A (both lanes).
        for (int r = 0; r < 17; r++) begin
            for (int l = 0; l < 2; l++) begin
                logic [9:0] row = (r < 16) ? 10'(r) : 10'd1023;
                step("R3", 1, 1, {row, 1'(l)}, 18'($urandom), 0, 0, '0, '0);
            end
        end

        // R9: write attempted during reset is dropped, storage survives.
        rst = 1'b1;
        step("R9", 1, 1, {10'd3, 1'b0}, 18'h33333, 1, 1, {10'd3, 3'd2}, 4'hF);
        rst = 1'b0;
        step("R9", 1, 0, {10'd3, 1'b0}, '0, 1, 0, {10'd3, 3'd2}, '0);

        // R2: wide write, narrow read of each slice.
        step("R2", 1, 1, {10'd1023, 1'b1}, 18'h2ABCD, 0, 0, '0, '0);
        step("R2", 0, 0, '0, '0, 1, 0, {10'd1023, 3'd4}, '0);
        check("R2 lane4 literal", 36'(b_dout), 36'h0000_0000D);
        step("R2", 0, 0, '0, '0, 1, 0, {10'd1023, 3'd7}, '0);
        check("R2 lane7 literal", 36'(b_dout), 36'h0000_0000A);

        // R8 / R1: narrow write keeps parity and other lanes.
        step("R8", 0, 0, '0, '0, 1, 1, {10'd1023, 3'd7}, 4'h5);
        step("R8", 1, 0, {10'd1023, 1'b1}, '0, 0, 0, '0, '0);
        check("R1 R8 parity kept", 36'(a_dout), 36'h0_0002_5BCD);

        // R4: read-first on a write.
        step("R4", 1, 1, {10'd1023, 1'b1}, 18'h11111, 0, 0, '0, '0);
        check("R4 old word", 36'(a_dout), 36'h0_0002_5BCD);
        step("R4", 1, 0, {10'd1023, 1'b1}, '0, 0, 0, '0, '0);
        check("R4 new word", 36'(a_dout), 36'h0_0001_1111);

        // R5: overlapping same-cycle writes, A wins.
        step("R5", 1, 1, {10'd2, 1'b0}, 18'h07777, 1, 1, {10'd2, 3'd1}, 4'h9);
        step("R5", 1, 0, {10'd2, 1'b0}, '0, 1, 0, {10'd2, 3'd1}, '0);
        check("R5 A wins narrow", 36'(b_dout), 36'h7);
        check("R5 A wins wide", 36'(a_dout), 36'h0_0000_7777);

        // R5: same row, disjoint bits: both land.
        step("R5", 1, 1, {10'd6, 1'b0}, 18'h1_2345, 1, 1, {10'd6, 3'd6}, 4'hC);
        step("R5", 0, 0, '0, '0, 1, 0, {10'd6, 3'd6}, '0);
        check("R5 B disjoint kept", 36'(b_dout), 36'hC);

        // R6: cross-port read of a same-cycle write returns old data.
        step("R6", 1, 1, {10'd4, 1'b0}, 18'h32468, 1, 0, {10'd4, 3'd0}, '0);
        step("R6", 0, 0, '0, '0, 1, 0, {10'd4, 3'd0}, '0);
        check("R6 new after", 36'(b_dout), 36'h8);

        // R7: disabled port with write enable high does nothing.
        step("R7", 0, 1, {10'd5, 1'b0}, 18'h3FFFF, 0, 1, {10'd5, 3'd1}, 4'hE);
        idle();
        step("R7", 1, 0, {10'd5, 1'b0}, '0, 1, 0, {10'd5, 3'd1}, '0);

        // Random traffic over a small set of rows to force collisions (R3 R5 R6).
        for (int i = 0; i < 3000; i++) begin
            logic [9:0] ra = ($urandom % 8 == 0) ? 10'd1023 : 10'($urandom % 16);
            logic [9:0] rb = ($urandom % 8 == 0) ? 10'd1023 : 10'($urandom % 16);
            step("R3", 1'($urandom % 4 != 0), 1'($urandom), {ra, 1'($urandom)}, 18'($urandom),
                       1'($urandom % 4 != 0), 1'($urandom), {rb, 3'($urandom)}, 4'($urandom));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule